// File: doc/BRIEF.md
# GPIO Bank Interrupt Event Controller

This block watches the already-synchronized input levels of one GPIO bank (up to 32 lines) and turns selected conditions on each line into pending events. Every line carries a 3-bit event selector that picks falling-edge, rising-edge, any-edge, low-level or high-level detection. Pending events gather in a status register. An enable mask decides which of them may drive the single interrupt output of the bank.

Software uses a simple register port. Writing ones to the enable register turns on the matching mask bits. Writing ones to the disable register turns them off. Reading the mask register returns the current enables. Reading the status register returns every pending event and clears them in the same access, so no separate acknowledge is needed. The selector codes and pin levels come from outside the block, which keeps no configuration store of its own.

The register port has no back-pressure. An access is presented for one cycle with `bus_en` high and always completes in that cycle. Read data appears on `bus_rdata` in the cycle after the access and is zero in every other cycle.

Top module: `gpio_evt_ctrl`

## Requirements
- R1: After reset the mask and status are zero, `irq_o` is low and `bus_rdata` is zero. Reset is asynchronous and active low, and forces `irq_o` low at once.
- R2: A write to offset 0x20 sets the mask bits where the written data has ones and leaves the other bits unchanged. A read of offset 0x28 returns the mask.
- R3: A write to offset 0x24 clears the mask bits where the written data has ones and leaves the other bits unchanged.
- R4: Selector code 1 records an event when a line goes from low to high. A high-to-low change on that line records nothing.
- R5: Selector code 0 records an event when a line goes from high to low. A low-to-high change on that line records nothing.
- R6: Selector code 2 records an event on every change of the line, in either direction.
- R7: Selector code 4 records an event in every cycle the line is high, and code 3 in every cycle the line is low. While the level holds, the status bit is set again after a clearing read.
- R8: A read of offset 0x2C returns the pending status bits and clears them in the same access.
- R9: An event detected in the same cycle as a status read stays pending. That read does not return it, and the next read does.
- R10: Selector codes 5, 6 and 7 never record an event, whatever the line does.
- R11: `irq_o` is high exactly when some status bit is set whose mask bit is also set. Status bits latch even while masked, so enabling a line that has a pending event raises `irq_o` after that write.
- R12: The line level present in the first cycle after reset is taken as the reference level. A line that is already high when reset is released does not record a rising edge.
- R13: Writes to offsets 0x28 and 0x2C change nothing. Reads of any offset other than 0x28 and 0x2C return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_lvl | input | N_LINES | Synchronized level of each line |
| evt_code | input | 3*N_LINES | Event selector of each line, line i at bits [3i+2:3i] |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | High for a write, low for a read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | N_LINES | Write data |
| bus_rdata | output | N_LINES | Read data, valid in the cycle after a read |
| irq_o | output | 1 | Bank interrupt |

## Verification
The hardest situation to reach from the ports is an edge that arrives in exactly the cycle the status register is read. In that cycle the clear and the new event compete for the same bit. The bench reaches it by changing a line in the same vector that issues the status read. It then expects zero read data, a high interrupt afterwards, and the event on the following read. The bench also holds a level condition across several clearing reads, and it releases reset while a rising-edge line is already high.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    EVT_FALL = 3'd0,
    EVT_RISE = 3'd1,
    EVT_BOTH = 3'd2,
    EVT_LOW  = 3'd3,
    EVT_HIGH = 3'd4
  } evt_sel_e;

  localparam int OFS_ENABLE  = 'h20;
  localparam int OFS_DISABLE = 'h24;
  localparam int OFS_MASK    = 'h28;
  localparam int OFS_STATUS  = 'h2C;

endpackage

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_evt_pkg::*;
#(
  parameter int N_LINES = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_LINES-1:0]        lvl_i,
  input  logic [CODE_W*N_LINES-1:0] code_i,
  output logic [N_LINES-1:0]        hit_o
);

  logic [N_LINES-1:0] prev_q;
  logic               primed_q;

  // Reference level: the first cycle after reset only loads prev_q.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= lvl_i;
      primed_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    logic [CODE_W-1:0] code;
    logic              rise, fall;

    assign code = code_i[i*CODE_W +: CODE_W];
    assign rise = primed_q &  lvl_i[i] & ~prev_q[i];
    assign fall = primed_q & ~lvl_i[i] &  prev_q[i];

    always_comb begin
      case (code)
        EVT_FALL: hit_o[i] = fall;
        EVT_RISE: hit_o[i] = rise;
        EVT_BOTH: hit_o[i] = rise | fall;
        EVT_LOW:  hit_o[i] = ~lvl_i[i];
        EVT_HIGH: hit_o[i] = lvl_i[i];
        default:  hit_o[i] = 1'b0;
      endcase
    end

    p_reserved_silent_r10: assert property (
      @(posedge clk) disable iff (!rst_n)
      (code > CODE_W'(EVT_HIGH)) |-> !hit_o[i]
    );
  end

endmodule

// File: rtl/gpio_evt_mask.sv
module gpio_evt_mask #(
  parameter int N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] set_i,
  input  logic [N_LINES-1:0] clr_i,
  output logic [N_LINES-1:0] mask_o
);

  logic [N_LINES-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= (mask_q | set_i) & ~clr_i;
  end

  assign mask_o = mask_q;

  p_set_sticks_r2: assert property (
    @(posedge clk) disable iff (!rst_n)
    (clr_i == '0) |=> ((mask_q & $past(set_i)) == $past(set_i))
  );

  p_clear_sticks_r3: assert property (
    @(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((mask_q & $past(clr_i)) == '0)
  );

endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status #(
  parameter int N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] hit_i,
  input  logic               rd_clr_i,
  output logic [N_LINES-1:0] status_o
);

  logic [N_LINES-1:0] status_q;
  logic [N_LINES-1:0] keep;

  // A read drops what it returns; new hits of the same cycle win.
  assign keep = rd_clr_i ? '0 : status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= keep | hit_i;
  end

  assign status_o = status_q;

  p_read_clears_r8: assert property (
    @(posedge clk) disable iff (!rst_n)
    rd_clr_i |=> ((status_q & ~$past(hit_i)) == '0)
  );

  p_hit_kept_r9: assert property (
    @(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(hit_i)) == $past(hit_i))
  );

endmodule

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
  import gpio_evt_pkg::*;
#(
  parameter int N_LINES = 32,
  parameter int ADDR_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_LINES-1:0]        pin_lvl,
  input  logic [CODE_W*N_LINES-1:0] evt_code,
  input  logic                      bus_en,
  input  logic                      bus_we,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [N_LINES-1:0]        bus_wdata,
  output logic [N_LINES-1:0]        bus_rdata,
  output logic                      irq_o
);

  localparam logic [ADDR_W-1:0] A_ENABLE  = ADDR_W'(OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_DISABLE = ADDR_W'(OFS_DISABLE);
  localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFS_STATUS);

  logic               wr_acc, rd_acc;
  logic [N_LINES-1:0] hit, mask_set, mask_clr, mask_vec, status_vec;
  logic [N_LINES-1:0] rd_val, rdata_q;
  logic               status_rd;

  assign wr_acc    = bus_en &  bus_we;
  assign rd_acc    = bus_en & ~bus_we;
  assign mask_set  = (wr_acc && bus_addr == A_ENABLE)  ? bus_wdata : '0;
  assign mask_clr  = (wr_acc && bus_addr == A_DISABLE) ? bus_wdata : '0;
  assign status_rd = rd_acc && bus_addr == A_STATUS;

  gpio_evt_detect #(.N_LINES(N_LINES)) u_detect (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (pin_lvl),
    .code_i (evt_code),
    .hit_o  (hit)
  );

  gpio_evt_mask #(.N_LINES(N_LINES)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (mask_set),
    .clr_i  (mask_clr),
    .mask_o (mask_vec)
  );

  gpio_evt_status #(.N_LINES(N_LINES)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_i    (hit),
    .rd_clr_i (status_rd),
    .status_o (status_vec)
  );

  always_comb begin
    case (bus_addr)
      A_MASK:   rd_val = mask_vec;
      A_STATUS: rd_val = status_vec;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rd_acc ? rd_val : '0;
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = |(status_vec & mask_vec);

  p_unmask_fires_r11: assert property (
    @(posedge clk) disable iff (!rst_n)
    (wr_acc && bus_addr == A_ENABLE && (bus_wdata & status_vec) != '0) |=> irq_o
  );

  p_idle_rdata_r13: assert property (
    @(posedge clk) disable iff (!rst_n)
    !rd_acc |=> (bus_rdata == '0)
  );

endmodule

// File: tb/gpio_evt_ctrl_test.sv
module gpio_evt_ctrl_test;

  localparam int N  = 32;
  localparam int AW = 8;

  localparam logic [1:0] OP_IDLE = 2'd0;
  localparam logic [1:0] OP_WR   = 2'd1;
  localparam logic [1:0] OP_RD   = 2'd2;

  localparam logic [7:0] A_EN  = 8'h20;
  localparam logic [7:0] A_DIS = 8'h24;
  localparam logic [7:0] A_MSK = 8'h28;
  localparam logic [7:0] A_STS = 8'h2C;

  // Base pattern: line1 high (falling code), line3 high (low code), line8 high (rising code).
  localparam logic [31:0] P0 = 32'h0000_010A;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] pins;
    logic [31:0] exp_rd;
    logic        exp_irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 41;
  localparam vec_t TBL [NV] = '{
    '{OP_IDLE, 8'h00,  32'h0, P0,          32'h0,  1'b0, 4'd1},  // R1
    '{OP_RD,   A_STS,  32'h0, P0,          32'h0,  1'b0, 4'd12}, // R12 line8 high at release
    '{OP_RD,   A_MSK,  32'h0, P0,          32'h0,  1'b0, 4'd1},  // R1
    '{OP_WR,   A_EN,   32'h5, P0,          32'h0,  1'b0, 4'd2},  // R2
    '{OP_RD,   A_MSK,  32'h0, P0,          32'h5,  1'b0, 4'd2},  // R2
    '{OP_WR,   A_EN,   32'h10, P0,         32'h0,  1'b0, 4'd2},  // R2
    '{OP_WR,   A_DIS,  32'h4, P0,          32'h0,  1'b0, 4'd3},  // R3
    '{OP_RD,   A_MSK,  32'h0, P0,          32'h11, 1'b0, 4'd3},  // R3
    '{OP_IDLE, 8'h00,  32'h0, P0|32'h1,    32'h0,  1'b1, 4'd4},  // R4 rise on line0
    '{OP_IDLE, 8'h00,  32'h0, P0,          32'h0,  1'b1, 4'd4},  // R4 fall ignored
    '{OP_RD,   A_STS,  32'h0, P0,          32'h1,  1'b0, 4'd8},  // R8
    '{OP_RD,   A_STS,  32'h0, P0,          32'h0,  1'b0, 4'd8},  // R8
    '{OP_IDLE, 8'h00,  32'h0, 32'h108,     32'h0,  1'b0, 4'd5},  // R5 fall on line1, masked
    '{OP_IDLE, 8'h00,  32'h0, P0,          32'h0,  1'b0, 4'd5},  // R5 rise ignored
    '{OP_WR,   A_EN,   32'h2, P0,          32'h0,  1'b1, 4'd11}, // R11 unmask pending
    '{OP_RD,   A_STS,  32'h0, P0,          32'h2,  1'b0, 4'd5},  // R5
    '{OP_IDLE, 8'h00,  32'h0, P0|32'h4,    32'h0,  1'b0, 4'd6},  // R6 rise line2
    '{OP_RD,   A_STS,  32'h0, P0|32'h4,    32'h4,  1'b0, 4'd6},  // R6
    '{OP_IDLE, 8'h00,  32'h0, P0,          32'h0,  1'b0, 4'd6},  // R6 fall line2
    '{OP_RD,   A_STS,  32'h0, P0,          32'h4,  1'b0, 4'd6},  // R6
    '{OP_IDLE, 8'h00,  32'h0, P0|32'h10,   32'h0,  1'b1, 4'd7},  // R7 high level line4
    '{OP_RD,   A_STS,  32'h0, P0|32'h10,   32'h10, 1'b1, 4'd7},  // R7 re-set while held
    '{OP_IDLE, 8'h00,  32'h0, P0,          32'h0,  1'b1, 4'd7},  // R7
    '{OP_RD,   A_STS,  32'h0, P0,          32'h10, 1'b0, 4'd7},  // R7
    '{OP_RD,   A_STS,  32'h0, P0,          32'h0,  1'b0, 4'd7},  // R7
    '{OP_IDLE, 8'h00,  32'h0, 32'h102,     32'h0,  1'b0, 4'd7},  // R7 low level line3
    '{OP_RD,   A_STS,  32'h0, P0,          32'h8,  1'b0, 4'd7},  // R7
    '{OP_RD,   A_STS,  32'h0, P0,          32'h0,  1'b0, 4'd7},  // R7
    '{OP_IDLE, 8'h00,  32'h0, P0|32'hE0,   32'h0,  1'b0, 4'd10}, // R10 reserved codes rise
    '{OP_IDLE, 8'h00,  32'h0, P0,          32'h0,  1'b0, 4'd10}, // R10 reserved codes fall
    '{OP_RD,   A_STS,  32'h0, P0,          32'h0,  1'b0, 4'd10}, // R10
    '{OP_RD,   A_STS,  32'h0, P0|32'h1,    32'h0,  1'b1, 4'd9},  // R9 edge during read
    '{OP_RD,   A_STS,  32'h0, P0|32'h1,    32'h1,  1'b0, 4'd9},  // R9
    '{OP_IDLE, 8'h00,  32'h0, P0,          32'h0,  1'b0, 4'd4},  // R4
    '{OP_WR,   A_MSK,  32'hFFFF_FFFF, P0,  32'h0,  1'b0, 4'd13}, // R13
    '{OP_RD,   A_MSK,  32'h0, P0,          32'h13, 1'b0, 4'd13}, // R13
    '{OP_WR,   A_STS,  32'hFFFF_FFFF, P0,  32'h0,  1'b0, 4'd13}, // R13
    '{OP_RD,   A_STS,  32'h0, P0,          32'h0,  1'b0, 4'd13}, // R13
    '{OP_RD,   8'h30,  32'h0, P0,          32'h0,  1'b0, 4'd13}, // R13
    '{OP_WR,   A_DIS,  32'hFFFF_FFFF, P0,  32'h0,  1'b0, 4'd3},  // R3
    '{OP_RD,   A_MSK,  32'h0, P0,          32'h0,  1'b0, 4'd3}   // R3
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    pin_lvl;
  logic [3*N-1:0]  evt_code;
  logic            bus_en, bus_we;
  logic [AW-1:0]   bus_addr;
  logic [N-1:0]    bus_wdata;
  logic [N-1:0]    bus_rdata;
  logic            irq_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  gpio_evt_ctrl #(.N_LINES(N), .ADDR_W(AW)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_lvl   (pin_lvl),
    .evt_code  (evt_code),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );

  task automatic drive(input logic [1:0] op, input logic [7:0] addr,
                       input logic [31:0] wd, input logic [31:0] pins);
    bus_en    = (op != OP_IDLE);
    bus_we    = (op == OP_WR);
    bus_addr  = addr;
    bus_wdata = wd;
    pin_lvl   = pins;
  endtask

  task automatic check(input logic [31:0] exp_rd, input logic exp_irq,
                       input int req, input int idx);
    n_chk++;
    if (bus_rdata !== exp_rd || irq_o !== exp_irq) begin
      n_fail++;
      $display("FAIL R%0d step %0d: rdata=%h exp=%h irq=%b exp=%b",
               req, idx, bus_rdata, exp_rd, irq_o, exp_irq);
    end
  endtask

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // Line codes: 0 rise, 1 fall, 2 both, 3 low, 4 high, 5..7 reserved, rest rise.
    for (int i = 0; i < N; i++) evt_code[3*i +: 3] = 3'd1;
    evt_code[3*1 +: 3] = 3'd0;
    evt_code[3*2 +: 3] = 3'd2;
    evt_code[3*3 +: 3] = 3'd3;
    evt_code[3*4 +: 3] = 3'd4;
    evt_code[3*5 +: 3] = 3'd5;
    evt_code[3*6 +: 3] = 3'd6;
    evt_code[3*7 +: 3] = 3'd7;
    drive(OP_IDLE, 8'h00, 32'h0, P0);
    repeat (3) @(negedge clk);
    check(32'h0, 1'b0, 1, -1); // R1 during reset
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].op, TBL[i].addr, TBL[i].wdata, TBL[i].pins);
      @(negedge clk);
      check(TBL[i].exp_rd, TBL[i].exp_irq, int'(TBL[i].req), i);
    end

    // R11: enable line0 while it rises
    drive(OP_WR, A_EN, 32'h1, P0 | 32'h1);
    @(negedge clk);
    check(32'h0, 1'b1, 11, 100);
    // R1: asynchronous reset with an active interrupt
    drive(OP_IDLE, 8'h00, 32'h0, P0 | 32'h1);
    rst_n = 1'b0;
    #1;
    check(32'h0, 1'b0, 1, 101);
    @(negedge clk);
    rst_n = 1'b1;
    drive(OP_RD, A_MSK, 32'h0, P0 | 32'h1);
    @(negedge clk);
    check(32'h0, 1'b0, 1, 102);
    // R12: line0 already high at release, no rising event
    drive(OP_RD, A_STS, 32'h0, P0 | 32'h1);
    @(negedge clk);
    check(32'h0, 1'b0, 12, 103);
    drive(OP_IDLE, 8'h00, 32'h0, P0);
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule